// File: doc/BRIEF.md
# Register Window Index Flattener

This block turns an architectural integer register number into an index into one flat physical register file. It serves a processor whose integer registers are split into three kinds. The first kind is a banked set of eight globals, selected by a global level. The second is a ring of overlapping register windows, selected by a window pointer. The third is a small scratch area for microcode. The flat space holds all the global banks first, then the whole window ring, then the scratch registers.

Two extra architectural ranges give another view of the register set, so that microcode can reach the window before the current one or the window after it. Their global part still selects the current global bank. A separate floating-point index goes through unchanged, with the same latency as the integer path. An index beyond the last alias range sets an error flag and forces the flat index to zero.

The mapping itself is combinational. An optional output register, present by default, adds one cycle of latency.

Top module: `reg_window_flattener`

## Requirements
- R1: For an architectural index i in 0..7, the flat index is i + 8*gl. With the defaults this gives 0..31.
- R2: For an index i in 8..31, the flat index is 32 + ((i - 8 - 16*cwp + 128) mod 128). Each window moves the ring by 16 entries, and the ring has 8*16 = 128 entries.
- R3: For an index i in 32..40 (the scratch registers), the flat index is i - 32 + 160. This places them directly after the ring.
- R4: For an index i in 41..72, let o = i - 41. If o < 8, the flat index is o + 8*gl. Otherwise it is the R2 mapping of index o with the window taken as cwp - 1. At cwp = 0 this wraps to window 7.
- R5: For an index i in 73..104, let o = i - 73. If o < 8, the flat index is o + 8*gl. Otherwise it is the R2 mapping of index o with the window taken as cwp + 1. At cwp = 7 this wraps to window 0.
- R6: For an index i of 105 or more, the error flag is 1 and the flat index is 0. For every smaller index the flag is 0.
- R7: The floating-point index output equals the floating-point index input.
- R8: With the output register enabled (the default), every output reflects the inputs sampled at the previous rising clock edge. While the active-low reset is held, the outputs are 0.
- R9: For every offset o of 8 or more, an alias index gives the same flat index as windowed index o does in the adjacent window. For the previous-window range that window is (cwp - 1) mod 8. For the next-window range it is (cwp + 1) mod 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| arch_idx | input | 8 | Architectural integer register index |
| win_ptr | input | 3 | Current window pointer |
| glob_lvl | input | 2 | Current global level |
| fp_idx_in | input | 6 | Floating-point register index |
| flat_idx | output | 8 | Flat physical integer register index |
| bad_idx | output | 1 | Invalid architectural index flag |
| fp_idx_out | output | 6 | Floating-point index, passed through |

## Verification
Two functions can fall in the same cycle: the ring wrap at the ends of the window pointer, and an access through an alias range to a neighbouring window. The bench provokes this by sweeping every valid index over every window pointer and global level, including cwp = 0 with the previous-window range and cwp = 7 with the next-window range. Each alias result is judged twice. First it is compared with a behavioural model of the formulas. Then it is compared with the model's value for the plain windowed register in the adjacent window, where the window number is wrapped independently. Invalid indices are applied together with changing floating-point indices, to show that the error path and the pass-through path do not disturb each other.

// File: rtl/rwf_pkg.sv
package rwf_pkg;

  // Which part of the flat space an architectural index resolves to
  typedef enum logic [2:0] {
    K_BANK      = 3'd0,
    K_RING_PREV = 3'd1,
    K_RING_CUR  = 3'd2,
    K_RING_NEXT = 3'd3,
    K_SCRATCH   = 3'd4,
    K_BAD       = 3'd5
  } idx_kind_e;

endpackage

// File: rtl/rwf_classify.sv
module rwf_classify
  import rwf_pkg::*;
#(
  parameter int ARCH_REGS    = 32,
  parameter int SCRATCH_REGS = 9,
  parameter int IDX_W        = 8,
  parameter int OFF_W        = 5
) (
  input  logic [IDX_W-1:0] arch_idx,
  output idx_kind_e        kind,
  output logic [OFF_W-1:0] slot,
  output logic             alias_hit
);

  localparam int SCR_END  = ARCH_REGS + SCRATCH_REGS;
  localparam int PREV_END = SCR_END + ARCH_REGS;
  localparam int NEXT_END = PREV_END + ARCH_REGS;

  // Offset inside an alias range: the first 8 go to the bank, the rest to a ring
  function automatic int alias_slot(input int rel);
    return (rel < 8) ? rel : rel - 8;
  endfunction

  always_comb begin
    int v;
    v         = int'(arch_idx);
    kind      = K_BAD;
    slot      = '0;
    alias_hit = 1'b0;
    if (v < 8) begin
      kind = K_BANK;
      slot = OFF_W'(v);
    end else if (v < ARCH_REGS) begin
      kind = K_RING_CUR;
      slot = OFF_W'(v - 8);
    end else if (v < SCR_END) begin
      kind = K_SCRATCH;
      slot = OFF_W'(v - ARCH_REGS);
    end else if (v < PREV_END) begin
      alias_hit = 1'b1;
      kind      = ((v - SCR_END) < 8) ? K_BANK : K_RING_PREV;
      slot      = OFF_W'(alias_slot(v - SCR_END));
    end else if (v < NEXT_END) begin
      alias_hit = 1'b1;
      kind      = ((v - PREV_END) < 8) ? K_BANK : K_RING_NEXT;
      slot      = OFF_W'(alias_slot(v - PREV_END));
    end
  end

endmodule

// File: rtl/rwf_ring_map.sv
module rwf_ring_map #(
  parameter int WINDOWS = 8,
  parameter int DELTA   = 0,
  parameter int OFF_W   = 5,
  parameter int CWP_W   = 3,
  parameter int RING_W  = 7
) (
  input  logic [CWP_W-1:0]  win_ptr,
  input  logic [OFF_W-1:0]  slot,
  output logic [RING_W-1:0] ring_idx
);

  localparam int RING = WINDOWS * 16;

  // Position of a window-relative slot in the ring, for window win_ptr+DELTA
  function automatic logic [RING_W-1:0] ring_pos(input logic [OFF_W-1:0] s,
                                                 input logic [CWP_W-1:0] w);
    int eff;
    int v;
    eff = (int'(w) + WINDOWS + DELTA) % WINDOWS;
    v   = int'(s) + RING - eff * 16;
    if (v >= RING) v = v - RING;
    return RING_W'(v);
  endfunction

  assign ring_idx = ring_pos(slot, win_ptr);

endmodule

// File: rtl/rwf_out_stage.sv
module rwf_out_stage #(
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end

endmodule

// File: rtl/reg_window_flattener.sv
module reg_window_flattener
  import rwf_pkg::*;
#(
  parameter int ARCH_REGS    = 32,
  parameter int MAX_LEVEL    = 3,
  parameter int WINDOWS      = 8,
  parameter int SCRATCH_REGS = 9,
  parameter int IDX_W        = 8,
  parameter int FP_W         = 6,
  parameter bit OUT_REG      = 1'b1,
  localparam int CWP_W     = (WINDOWS > 1) ? $clog2(WINDOWS) : 1,
  localparam int GL_W      = (MAX_LEVEL > 0) ? $clog2(MAX_LEVEL + 1) : 1,
  localparam int GLOBALS   = (MAX_LEVEL + 1) * 8,
  localparam int RING      = WINDOWS * 16,
  localparam int FLAT_SIZE = GLOBALS + RING + SCRATCH_REGS,
  localparam int FLAT_W    = $clog2(FLAT_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  arch_idx,
  input  logic [CWP_W-1:0]  win_ptr,
  input  logic [GL_W-1:0]   glob_lvl,
  input  logic [FP_W-1:0]   fp_idx_in,
  output logic [FLAT_W-1:0] flat_idx,
  output logic              bad_idx,
  output logic [FP_W-1:0]   fp_idx_out
);

  localparam int OFF_W  = $clog2((ARCH_REGS > SCRATCH_REGS) ? ARCH_REGS : SCRATCH_REGS);
  localparam int RING_W = $clog2(RING);
  localparam int OUT_W  = 1 + FLAT_W + FP_W;

  idx_kind_e         kind;
  logic [OFF_W-1:0]  slot;
  logic              alias_hit;
  logic [RING_W-1:0] ring_idx [3];
  logic [FLAT_W-1:0] flat_c;
  logic              bad_c;
  logic [OUT_W-1:0]  stage_d;
  logic [OUT_W-1:0]  stage_q;

  rwf_classify #(
    .ARCH_REGS   (ARCH_REGS),
    .SCRATCH_REGS(SCRATCH_REGS),
    .IDX_W       (IDX_W),
    .OFF_W       (OFF_W)
  ) u_classify (
    .arch_idx (arch_idx),
    .kind     (kind),
    .slot     (slot),
    .alias_hit(alias_hit)
  );

  // One ring mapper per window offset: previous, current, next
  for (genvar g = 0; g < 3; g++) begin : g_ring
    rwf_ring_map #(
      .WINDOWS(WINDOWS),
      .DELTA  (g - 1),
      .OFF_W  (OFF_W),
      .CWP_W  (CWP_W),
      .RING_W (RING_W)
    ) u_map (
      .win_ptr (win_ptr),
      .slot    (slot),
      .ring_idx(ring_idx[g])
    );
  end

  function automatic logic [FLAT_W-1:0] bank_pos(input logic [OFF_W-1:0] s,
                                                 input logic [GL_W-1:0] lvl);
    return FLAT_W'(int'(s[2:0]) + 8 * int'(lvl));
  endfunction

  always_comb begin
    bad_c  = 1'b0;
    flat_c = '0;
    unique case (kind)
      K_BANK:      flat_c = bank_pos(slot, glob_lvl);
      K_RING_PREV: flat_c = FLAT_W'(GLOBALS + int'(ring_idx[0]));
      K_RING_CUR:  flat_c = FLAT_W'(GLOBALS + int'(ring_idx[1]));
      K_RING_NEXT: flat_c = FLAT_W'(GLOBALS + int'(ring_idx[2]));
      K_SCRATCH:   flat_c = FLAT_W'(GLOBALS + RING + int'(slot));
      default:     bad_c  = 1'b1;
    endcase
  end

  assign stage_d = {bad_c, flat_c, fp_idx_in};

  rwf_out_stage #(
    .W      (OUT_W),
    .OUT_REG(OUT_REG)
  ) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (stage_d),
    .q    (stage_q)
  );

  assign bad_idx    = stage_q[OUT_W-1];
  assign flat_idx   = stage_q[OUT_W-2 -: FLAT_W];
  assign fp_idx_out = stage_q[FP_W-1:0];

endmodule

// File: rtl/reg_window_flattener_chk.sv
module reg_window_flattener_chk #(
  parameter int ARCH_REGS    = 32,
  parameter int MAX_LEVEL    = 3,
  parameter int WINDOWS      = 8,
  parameter int SCRATCH_REGS = 9,
  parameter int IDX_W        = 8,
  parameter int FP_W         = 6,
  parameter bit OUT_REG      = 1'b1,
  parameter int CWP_W        = 3,
  parameter int GL_W         = 2,
  parameter int FLAT_W       = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IDX_W-1:0]  arch_idx,
  input logic [CWP_W-1:0]  win_ptr,
  input logic [GL_W-1:0]   glob_lvl,
  input logic [FP_W-1:0]   fp_idx_in,
  input logic [FLAT_W-1:0] flat_idx,
  input logic              bad_idx,
  input logic [FP_W-1:0]   fp_idx_out,
  input logic              alias_hit
);

  localparam int GLOBALS = (MAX_LEVEL + 1) * 8;
  localparam int RING    = WINDOWS * 16;
  localparam int SCR_END = ARCH_REGS + SCRATCH_REGS;
  localparam int LIMIT   = SCR_END + 2 * ARCH_REGS;

  logic [IDX_W-1:0] q_idx;
  logic [GL_W-1:0]  q_gl;
  logic [FP_W-1:0]  q_fp;
  logic             q_alias;
  logic             primed;

  // Inputs as seen by the current outputs
  if (OUT_REG) begin : g_seen_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_idx <= '0; q_gl <= '0; q_fp <= '0; q_alias <= 1'b0; primed <= 1'b0;
      end else begin
        q_idx <= arch_idx; q_gl <= glob_lvl; q_fp <= fp_idx_in;
        q_alias <= alias_hit; primed <= 1'b1;
      end
    end
  end else begin : g_seen_wire
    assign q_idx   = arch_idx;
    assign q_gl    = glob_lvl;
    assign q_fp    = fp_idx_in;
    assign q_alias = alias_hit;
    assign primed  = 1'b1;
  end

  a_r6_flag_zeroes_index: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    bad_idx |-> (flat_idx == '0));

  a_r6_flag_range: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    bad_idx == (int'(q_idx) >= LIMIT));

  a_r7_fp_through: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    fp_idx_out == q_fp);

  a_r1_bank_select: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (int'(q_idx) < 8) |-> (int'(flat_idx) == int'(q_idx) + 8 * int'(q_gl)));

  a_r2_ring_region: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (int'(q_idx) >= 8 && int'(q_idx) < ARCH_REGS) |->
      (int'(flat_idx) >= GLOBALS && int'(flat_idx) < GLOBALS + RING));

  a_r3_scratch_place: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (int'(q_idx) >= ARCH_REGS && int'(q_idx) < SCR_END) |->
      (int'(flat_idx) == GLOBALS + RING + int'(q_idx) - ARCH_REGS));

  // R4, R5: alias ranges never land in the scratch area and never flag
  a_r4_alias_valid: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    q_alias |-> (!bad_idx && int'(flat_idx) < GLOBALS + RING));

  if (OUT_REG) begin : g_rst_chk
    a_r8_reset_zero: assert property (@(posedge clk)
      !rst_n |-> (flat_idx == '0 && !bad_idx && fp_idx_out == '0));
  end

endmodule

bind reg_window_flattener reg_window_flattener_chk #(
  .ARCH_REGS   (ARCH_REGS),
  .MAX_LEVEL   (MAX_LEVEL),
  .WINDOWS     (WINDOWS),
  .SCRATCH_REGS(SCRATCH_REGS),
  .IDX_W       (IDX_W),
  .FP_W        (FP_W),
  .OUT_REG     (OUT_REG),
  .CWP_W       (CWP_W),
  .GL_W        (GL_W),
  .FLAT_W      (FLAT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arch_idx  (arch_idx),
  .win_ptr   (win_ptr),
  .glob_lvl  (glob_lvl),
  .fp_idx_in (fp_idx_in),
  .flat_idx  (flat_idx),
  .bad_idx   (bad_idx),
  .fp_idx_out(fp_idx_out),
  .alias_hit (alias_hit)
);

// File: tb/reg_window_flattener_bench.sv
`timescale 1ns/1ps
module reg_window_flattener_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] arch_idx = '0;
  logic [2:0] win_ptr = '0;
  logic [1:0] glob_lvl = '0;
  logic [5:0] fp_idx_in = '0;
  logic [7:0] flat_idx;
  logic       bad_idx;
  logic [5:0] fp_idx_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    int    flat;
    int    bad;
    int    fp;
    int    alt;
    string req;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  reg_window_flattener u_reg_window_flattener (
    .clk       (clk),
    .rst_n     (rst_n),
    .arch_idx  (arch_idx),
    .win_ptr   (win_ptr),
    .glob_lvl  (glob_lvl),
    .fp_idx_in (fp_idx_in),
    .flat_idx  (flat_idx),
    .bad_idx   (bad_idx),
    .fp_idx_out(fp_idx_out)
  );

  // Behavioural model: 4 banks of 8, ring of 8 windows x 16, 9 scratch
  function automatic int win_map(int r, int c);
    return 32 + (((r - 8) - c * 16 + 128) % 128);
  endfunction

  function automatic int ref_flat(int i, int c, int g);
    int o;
    if (i < 8)  return i + 8 * g;
    if (i < 32) return win_map(i, c);
    if (i < 41) return 160 + (i - 32);
    if (i < 73) begin
      o = i - 41;
      return (o < 8) ? o + 8 * g : win_map(o, c - 1);
    end
    if (i < 105) begin
      o = i - 73;
      return (o < 8) ? o + 8 * g : win_map(o, c + 1);
    end
    return -1;
  endfunction

  function automatic string req_of(int i);
    if (i < 8)   return "R1";
    if (i < 32)  return "R2";
    if (i < 41)  return "R3";
    if (i < 73)  return "R4";
    if (i < 105) return "R5";
    return "R6";
  endfunction

  task automatic chk(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compare_head();
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(e.req, int'(flat_idx), e.flat);
      chk("R6", int'(bad_idx), e.bad);
      chk("R7", int'(fp_idx_out), e.fp);
      if (e.alt >= 0) chk("R9", int'(flat_idx), e.alt);
    end
  endtask

  task automatic step(int i, int c, int g, int f);
    exp_t e;
    int   r;
    @(negedge clk);
    compare_head();
    arch_idx  = 8'(i);
    win_ptr   = 3'(c);
    glob_lvl  = 2'(g);
    fp_idx_in = 6'(f);
    r      = ref_flat(i, c, g);
    e.flat = (r < 0) ? 0 : r;
    e.bad  = (r < 0) ? 1 : 0;
    e.fp   = f;
    e.req  = req_of(i);
    e.alt  = -1;
    // R9: alias ring offsets equal the plain windowed index in the neighbour window
    if (i >= 49 && i < 73)  e.alt = ref_flat(i - 41, (c + 7) % 8, g);
    if (i >= 81 && i < 105) e.alt = ref_flat(i - 73, (c + 1) % 8, g);
    exp_q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    // R8: outputs held at zero under reset even with live inputs
    arch_idx = 8'd20; win_ptr = 3'd3; glob_lvl = 2'd2; fp_idx_in = 6'd45;
    repeat (3) @(negedge clk);
    chk("R8", int'(flat_idx), 0);
    chk("R8", int'(bad_idx), 0);
    chk("R8", int'(fp_idx_out), 0);
    rst_n = 1'b1;

    // R8: one cycle of latency; change input, outputs must hold until the edge
    step(5, 0, 1, 7);
    @(negedge clk);
    arch_idx = 8'd6;
    #1;
    chk("R8", int'(flat_idx), 13);
    compare_head();
    exp_q.delete();

    // Full sweep of valid indices, all windows and levels (R1..R5, R9 wraps)
    for (int c = 0; c < 8; c++)
      for (int g = 0; g < 4; g++)
        for (int i = 0; i < 105; i++)
          step(i, c, g, (i * 7 + c + g) % 64);

    // R6: invalid indices with moving fp index (R7)
    for (int i = 105; i < 256; i++)
      step(i, i % 8, i % 4, (i * 3) % 64);

    // Boundaries back to back: last valid, first invalid, wrap corners
    step(104, 7, 3, 63);
    step(105, 7, 3, 0);
    step(49, 0, 0, 1);
    step(81, 7, 0, 2);
    step(255, 0, 0, 33);
    step(0, 0, 0, 0);

    @(negedge clk);
    compare_head();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

endmodule